// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Unit

This block is the register and command front end of an eight-line programmable interrupt controller. Software reaches it over a two-address byte bus with a one-bit address, a write strobe, a read strobe and 8-bit data. Through that bus it programs the vector base, the mask and the mode bits with a short initialization word sequence. It then issues operational commands: end-of-interrupt variants, priority rotation, choice of which register a read returns, and a polled read. A sibling block captures the request lines and presents them on `pend_i`. This unit tells that block which request bits to drop through one-cycle pulses on `pend_clr_o`. Whether a line is level-sensitive comes in on `lvl_i`.

Priority is rotating. Starting at the current offset and stepping upward modulo 8, the first unmasked pending line is the candidate. It wins only if it comes strictly before the highest-ranked in-service line in the same order. While a winner exists and no initialization sequence is in progress, the registered `irq_o` is high. A processor acknowledge (`ack_i`) returns the vector, which is the base with the winning line in its low three bits. When nothing qualifies, the vector carries line 7 and is treated as spurious.

The bus and the acknowledge are plain strobes with no back-pressure: every strobe is accepted in the cycle it is seen. Read data and the acknowledge vector are valid combinationally in the strobe cycle. If several strobes come in one cycle, a write wins over a read, and a read wins over an acknowledge. The lower-priority strobes are then ignored.

Top module: `pic_cmd_unit`

## Requirements
- R1: After reset the mask, the in-service set, the vector base, the rotation offset and all mode bits are zero. `irq_o` is low, a read at address 1 returns 0, and an acknowledge with no pending line returns vector 0x07.
- R2: A write to address 0 with bit 4 set clears all state and begins initialization. `irq_o` is low from the next cycle until the sequence has finished. Bit 0 of that write records whether a fourth word follows.
- R3: The next address-1 write stores the vector base as data AND 0xF8. The one after it ends the sequence, unless a fourth word is due. The fourth word sets nested mode (`nested_mode_o`) from bit 4 and automatic end-of-interrupt from bit 1.
- R4: Outside initialization, an address-1 write loads the mask (bit n = 1 masks line n), and an address-1 read returns the mask.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode word. When bit 1 is set, bit 0 chooses the address-0 read source: 1 = in-service, 0 = pending. When bit 6 is set, bit 5 drives `spec_mask_o`.
- R6: The winner is the first unmasked pending line from the offset upward, modulo 8, provided it ranks strictly above every in-service line. `irq_o` reflects the presence of a winner one cycle after the state that produced it.
- R7: An acknowledge returns base OR winning line. In normal mode it sets that line's in-service bit and pulses its `pend_clr_o` bit, unless `lvl_i` marks the line level-sensitive. With no winner it returns base OR 7 and changes nothing.
- R8: In automatic end-of-interrupt mode an acknowledge leaves the in-service set unchanged. If rotate-on-auto is on, it sets the offset to line+1. Command code 0 turns rotate-on-auto off and code 4 turns it on.
- R9: Command code 1 (bits 7:5) clears the highest-ranked in-service bit. Code 5 does the same and also sets the offset to that line+1.
- R10: Code 3 clears the in-service bit named by bits 2:0. Code 7 does that and also sets the offset to the line+1. Code 6 only sets the offset to bits 2:0 plus 1. Code 2 changes nothing. All offset sums wrap modulo 8.
- R11: Mode-word bit 2 arms a poll. The next read, at either address, returns the winning line (upper bits zero), clears its in-service bit and pulses its `pend_clr_o` bit. If there is no winner it returns 7. The poll is then disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | Register address select |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| pend_i | input | 8 | Pending request bits from the capture block |
| lvl_i | input | 8 | Per-line level-sensitive flags |
| pend_clr_o | output | 8 | One-cycle clear pulses to the capture block |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_vec_o | output | 8 | Vector number returned on acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| nested_mode_o | output | 1 | Nested mode selected by the fourth word |
| spec_mask_o | output | 1 | Special mask mode flag |

## Verification
A wrong in-service set or a wrong offset is hidden until the next acknowledge or poll, which then returns the wrong line number. A selected in-service read shows the in-service set directly in the very next cycle. A stuck initialization step keeps `irq_o` low and makes address-1 writes miss the mask, so a mask read-back exposes it at once. The directed sequences walk the offset round the ring, so a rotation error moves the winning vector within a single acknowledge.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  // Initialization progress
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_step_t;

  // Operational command codes, bits 7:5 of an address-0 command byte
  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_code_t;

  // Decoded address-0 write
  typedef struct packed {
    logic     is_init;
    logic     is_mode;
    logic     is_op;
    op_code_t op;
    logic     want4;
    logic     poll_arm;
    logic     sel_we;
    logic     sel_val;
    logic     smm_we;
    logic     smm_val;
  } cmd_t;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] mask,
  input  logic [LW-1:0]    off,
  output logic [LW:0]      rank
);
  // rank = distance from off to the first set bit, LINES when none
  always_comb begin
    rank = (LW+1)'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      if (mask[LW'(k) + off]) rank = (LW+1)'(k);
    end
  end
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic [7:0] data,
  output cmd_t       cmd
);
  always_comb begin
    cmd.is_init  = data[4];
    cmd.is_mode  = !data[4] && data[3];
    cmd.is_op    = !data[4] && !data[3];
    cmd.op       = op_code_t'(data[7:5]);
    cmd.want4    = data[0];
    cmd.poll_arm = data[2];
    cmd.sel_we   = data[1];
    cmd.sel_val  = data[0];
    cmd.smm_we   = data[6];
    cmd.smm_val  = data[5];
  end
endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
  import pic_cmd_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_a0,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] lvl_i,
  output logic [LINES-1:0] pend_clr_o,
  input  logic          ack_i,
  output logic [DW-1:0] ack_vec_o,
  output logic          irq_o,
  output logic          nested_mode_o,
  output logic          spec_mask_o
);
  localparam int LW = $clog2(LINES);
  localparam int BW = DW - LW;
  localparam logic [LW:0] NONE = (LW+1)'(LINES);

  // state
  logic [LINES-1:0] imr_q, isr_q;
  logic [BW-1:0]    base_q;
  logic [LW-1:0]    off_q;
  init_step_t       step_q;
  logic want4_q, aeoi_q, rot_aeoi_q, nest_q, smm_q, rsel_q, poll_q, irq_q;

  // strobe arbitration
  logic do_wr, do_rd, do_ack, poll_rd;
  assign do_wr   = bus_wr;
  assign do_rd   = bus_rd && !bus_wr;
  assign do_ack  = ack_i && !bus_wr && !bus_rd;
  assign poll_rd = do_rd && poll_q;

  cmd_t cmd;
  pic_cmd_decode u_dec (.data(bus_wdata), .cmd(cmd));

  logic cmd_wr, init_wr;
  assign cmd_wr  = do_wr && !bus_a0;
  assign init_wr = cmd_wr && cmd.is_init;

  // priority resolution
  logic [LINES-1:0] req;
  logic [LW:0]      req_rank, isr_rank;
  assign req = pend_i & ~imr_q;

  pic_prio_find #(.LINES(LINES)) u_req_rank (.mask(req),   .off(off_q), .rank(req_rank));
  pic_prio_find #(.LINES(LINES)) u_isr_rank (.mask(isr_q), .off(off_q), .rank(isr_rank));

  logic          win_ok, isr_any;
  logic [LW-1:0] win_line, isr_top;
  assign win_ok   = (req_rank != NONE) && (req_rank < isr_rank);
  assign win_line = req_rank[LW-1:0] + off_q;
  assign isr_any  = (isr_rank != NONE);
  assign isr_top  = isr_rank[LW-1:0] + off_q;

  logic [LW-1:0] resp_line;
  assign resp_line = win_ok ? win_line : {LW{1'b1}};

  // combinational outputs
  always_comb begin
    if (poll_q)      bus_rdata = {{BW{1'b0}}, resp_line};
    else if (bus_a0) bus_rdata = DW'(imr_q);
    else if (rsel_q) bus_rdata = DW'(isr_q);
    else             bus_rdata = DW'(pend_i);
  end

  assign ack_vec_o = {base_q, resp_line};

  always_comb begin
    pend_clr_o = '0;
    if (poll_rd && win_ok) pend_clr_o[win_line] = 1'b1;
    else if (do_ack && win_ok && !lvl_i[win_line]) pend_clr_o[win_line] = 1'b1;
  end

  assign irq_o         = irq_q;
  assign nested_mode_o = nest_q;
  assign spec_mask_o   = smm_q;

  // register updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q <= '0; isr_q <= '0; base_q <= '0; off_q <= '0;
      step_q <= ST_NORM; want4_q <= 1'b0; aeoi_q <= 1'b0;
      rot_aeoi_q <= 1'b0; nest_q <= 1'b0; smm_q <= 1'b0;
      rsel_q <= 1'b0; poll_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= (step_q == ST_NORM) && win_ok && !init_wr;
      if (init_wr) begin
        imr_q <= '0; isr_q <= '0; base_q <= '0; off_q <= '0;
        aeoi_q <= 1'b0; rot_aeoi_q <= 1'b0; nest_q <= 1'b0;
        smm_q <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0;
        want4_q <= cmd.want4;
        step_q <= ST_BASE;
      end else if (cmd_wr && cmd.is_mode) begin
        if (cmd.poll_arm) poll_q <= 1'b1;
        if (cmd.sel_we)   rsel_q <= cmd.sel_val;
        if (cmd.smm_we)   smm_q  <= cmd.smm_val;
      end else if (cmd_wr && cmd.is_op) begin
        unique case (cmd.op)
          OP_ROT_CLR: rot_aeoi_q <= 1'b0;
          OP_ROT_SET: rot_aeoi_q <= 1'b1;
          OP_EOI: if (isr_any) isr_q[isr_top] <= 1'b0;
          OP_REOI: if (isr_any) begin
            isr_q[isr_top] <= 1'b0;
            off_q <= isr_top + LW'(1);
          end
          OP_SEOI: isr_q[bus_wdata[LW-1:0]] <= 1'b0;
          OP_SETPRI: off_q <= bus_wdata[LW-1:0] + LW'(1);
          OP_RSEOI: begin
            isr_q[bus_wdata[LW-1:0]] <= 1'b0;
            off_q <= bus_wdata[LW-1:0] + LW'(1);
          end
          default: ;
        endcase
      end else if (do_wr && bus_a0) begin
        unique case (step_q)
          ST_NORM: imr_q <= bus_wdata[LINES-1:0];
          ST_BASE: begin
            base_q <= bus_wdata[DW-1:LW];
            step_q <= ST_CASC;
          end
          ST_CASC: step_q <= want4_q ? ST_MODE : ST_NORM;
          ST_MODE: begin
            nest_q <= bus_wdata[4];
            aeoi_q <= bus_wdata[1];
            step_q <= ST_NORM;
          end
          default: step_q <= ST_NORM;
        endcase
      end else if (poll_rd) begin
        poll_q <= 1'b0;
        if (win_ok) isr_q[win_line] <= 1'b0;
      end else if (do_ack && win_ok) begin
        if (aeoi_q) begin
          if (rot_aeoi_q) off_q <= win_line + LW'(1);
        end else begin
          isr_q[win_line] <= 1'b1;
        end
      end
    end
  end

  // assertions
  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> !irq_o);

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_NORM && win_ok && !init_wr) |=> irq_o);

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && win_ok && !aeoi_q) |=> isr_q[$past(win_line)]);

  p_aeoi_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && aeoi_q) |=> $stable(isr_q));

  p_rot_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd.is_op && cmd.op == OP_RSEOI)
      |=> off_q == $past(bus_wdata[LW-1:0]) + LW'(1));

  p_poll_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> !poll_q);

  p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr_o));

endmodule

// File: tb/pic_cmd_unit_tb.sv
module pic_cmd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, ack_i = 1'b0;
  logic [7:0] bus_wdata = '0, pend_i = '0, lvl_i = '0;
  logic [7:0] bus_rdata, pend_clr_o, ack_vec_o;
  logic irq_o, nested_mode_o, spec_mask_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pic_cmd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend_i), .lvl_i(lvl_i),
    .pend_clr_o(pend_clr_o), .ack_i(ack_i), .ack_vec_o(ack_vec_o), .irq_o(irq_o),
    .nested_mode_o(nested_mode_o), .spec_mask_o(spec_mask_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); bus_a0 = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d, output logic [7:0] clr);
    @(negedge clk); bus_a0 = a; bus_rd = 1'b1; #1; d = bus_rdata; clr = pend_clr_o;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v, output logic [7:0] clr);
    @(negedge clk); ack_i = 1'b1; #1; v = ack_vec_o; clr = pend_clr_o;
    @(negedge clk); ack_i = 1'b0;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic t_reset();
    logic [7:0] d, c;
    chk("R1 irq", irq_o, 0);
    chk("R1 nested", nested_mode_o, 0);
    rd(1'b1, d, c); chk("R1 mask", d, 8'h00);
    ack(d, c); chk("R1 vec", d, 8'h07);
  endtask

  task automatic t_init();
    logic [7:0] d, c;
    pend_i = 8'h01; settle(); settle();
    chk("R6 irq before init", irq_o, 1);
    wr(1'b0, 8'h11);
    chk("R2 irq low", irq_o, 0);
    wr(1'b1, 8'h4F); chk("R2 irq low mid", irq_o, 0);
    wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    settle(); chk("R2 irq back", irq_o, 1);
    chk("R3 nested off", nested_mode_o, 0);
    pend_i = 8'h00;
    ack(d, c); chk("R3 base masked", d, 8'h4F);
  endtask

  task automatic t_prio_eoi();
    logic [7:0] d, c;
    pend_i = 8'h28; ack(d, c);
    chk("R7 vec", d, 8'h4B); chk("R7 clr", c, 8'h08);
    wr(1'b0, 8'h0B); rd(1'b0, d, c); chk("R5 isr read", d, 8'h08);
    pend_i = 8'h20; settle(); settle(); chk("R6 blocked irq", irq_o, 0);
    ack(d, c); chk("R7 spurious", d, 8'h4F); chk("R7 spurious clr", c, 8'h00);
    pend_i = 8'h01; settle(); settle(); chk("R6 preempt irq", irq_o, 1);
    ack(d, c); chk("R7 vec0", d, 8'h48);
    wr(1'b0, 8'h20); rd(1'b0, d, c); chk("R9 eoi", d, 8'h08);
    wr(1'b0, 8'hA0); rd(1'b0, d, c); chk("R9 rot eoi", d, 8'h00);
    pend_i = 8'h21; ack(d, c); chk("R9 offset4 vec", d, 8'h4D);
  endtask

  task automatic t_specific();
    logic [7:0] d, c;
    wr(1'b0, 8'h65); rd(1'b0, d, c); chk("R10 seoi", d, 8'h00);
    wr(1'b0, 8'hC2);
    pend_i = 8'h41; ack(d, c); chk("R10 setpri vec", d, 8'h4E);
    wr(1'b0, 8'hE6); rd(1'b0, d, c); chk("R10 rseoi isr", d, 8'h00);
    ack(d, c); chk("R10 rseoi offset", d, 8'h48);
    wr(1'b0, 8'h40); rd(1'b0, d, c); chk("R10 nop", d, 8'h01);
  endtask

  task automatic t_mask_level();
    logic [7:0] d, c;
    wr(1'b1, 8'h81); rd(1'b1, d, c); chk("R4 mask read", d, 8'h81);
    pend_i = 8'h40; ack(d, c); chk("R4 masked vec", d, 8'h4F);
    wr(1'b1, 8'h00);
    lvl_i = 8'h01; pend_i = 8'h01; settle(); settle();
    chk("R6 equal rank irq", irq_o, 0);
    wr(1'b0, 8'h60);
    ack(d, c); chk("R7 level vec", d, 8'h48); chk("R7 level clr", c, 8'h00);
    lvl_i = 8'h00; wr(1'b0, 8'h60);
  endtask

  task automatic t_poll();
    logic [7:0] d, c;
    pend_i = 8'h10; wr(1'b0, 8'h0C);
    rd(1'b1, d, c); chk("R11 poll line", d, 8'h04); chk("R11 poll clr", c, 8'h10);
    rd(1'b0, d, c); chk("R11 disarmed", d, 8'h00);
    pend_i = 8'h00; wr(1'b0, 8'h0C);
    rd(1'b0, d, c); chk("R11 poll none", d, 8'h07); chk("R11 none clr", c, 8'h00);
    wr(1'b0, 8'h68); chk("R5 spec mask", spec_mask_o, 1);
  endtask

  task automatic t_aeoi();
    logic [7:0] d, c;
    wr(1'b0, 8'h11); chk("R2 spec mask cleared", spec_mask_o, 0);
    rd(1'b1, d, c); chk("R2 mask cleared", d, 8'h00);
    wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h12);
    chk("R3 nested on", nested_mode_o, 1);
    wr(1'b0, 8'h80);
    pend_i = 8'h04; ack(d, c); chk("R8 vec", d, 8'h22); chk("R8 clr", c, 8'h04);
    wr(1'b0, 8'h0B); rd(1'b0, d, c); chk("R8 isr untouched", d, 8'h00);
    pend_i = 8'h05; ack(d, c); chk("R8 rotated", d, 8'h20);
    wr(1'b0, 8'h00);
    ack(d, c); chk("R8 rot off a", d, 8'h22);
    ack(d, c); chk("R8 rot off b", d, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_init();
    t_prio_eoi();
    t_specific();
    t_mask_level();
    t_poll();
    t_aeoi();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule